// File: doc/BRIEF.md
# Single-Wire Debug Pin Handshake Controller

This block is the target-side handshake engine for a single-wire, open-drain style debug pin. It watches the pin level and, with counters running on the debug clock, detects when a host holds the pin low long enough to ask for resynchronisation. Once the host lets the pin go, the block answers with a timed low pulse of its own. This sync request also kills any debug command still in flight.

A second duty is telling the host that a debug command has finished. When hardware handshaking is switched on, completion produces a short low pulse on the pin. When it is off, no pulse appears and the host relies on polling a status byte, whose valid flag this block keeps. Every pulse the block drives ends with one cycle of active high drive to speed up the rising edge. The pin is then left to its pull-up. The block has no data stream, so all of its pins are plain control and status levels or strobes.

Top module: `dbg_pin_handshake`

## Requirements
- R1: A sync request is recognised when the synchronised pin level has been low for 128 consecutive debug clock samples. A low period of 127 samples is not recognised. The raw pin passes through two flops before counting, so recognition occurs on the clock edge 130 cycles after the pin first reads low.
- R2: When `cmd_done` is sampled high while a command is pending, the handshake is enabled, and no sync request is recognised in that cycle, `pin_drive_low` is high for exactly 16 cycles, starting the cycle after. It is followed by exactly one cycle of `pin_drive_high`, and then both are low.
- R3: The handshake is disabled after reset. `ack_on_cmd` enables it and `ack_off_cmd` disables it. If both are sampled high together, the handshake ends up disabled.
- R4: With the handshake disabled, completion drives nothing on the pin. In every mode, a completion of a pending command sets `status_valid` one cycle later, and `cmd_start` clears it.
- R5: After a sync request is recognised, the block waits until the synchronised pin has been high for two consecutive samples. It then drives `pin_drive_low` for exactly 128 cycles, followed by one cycle of `pin_drive_high`.
- R6: `cmd_abort` is a one-cycle pulse, issued in the cycle a sync request is recognised while a command is pending. The aborted command leaves nothing pending, so a later `cmd_done` produces neither an acknowledge pulse nor `status_valid`.
- R7: A sync request recognised while an acknowledge pulse is in progress ends that pulse in the next cycle, with no speedup. The sync response of R5 follows.
- R8: `pin_drive_low` and `pin_drive_high` are never high in the same cycle.
- R9: The low-time counter saturates. A pin held low for any length of time produces exactly one recognition and exactly one sync response.
- R10: The block's own sync-response low pulse is never taken as a new sync request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Raw level read back from the debug pin (1 = high) |
| cmd_start | input | 1 | Strobe: a decoded command has begun executing |
| cmd_done | input | 1 | Strobe: the pending command has completed |
| ack_on_cmd | input | 1 | Strobe: enable hardware acknowledge pulses |
| ack_off_cmd | input | 1 | Strobe: disable hardware acknowledge pulses |
| pin_drive_low | output | 1 | Drive the pin low |
| pin_drive_high | output | 1 | Drive the pin high (speedup) |
| cmd_abort | output | 1 | One-cycle strobe: pending command aborted by sync |
| status_valid | output | 1 | Completion flag for software polling |

## Verification
A wrong low-time count shows up as a sync response that starts early after a 127-cycle low, or never starts after a long one. It also shows as an abort strobe one cycle off from the reference. Any of these is visible within about 130 cycles of the host pulling the pin low.

A corrupted pulse timer lengthens or shortens a drive-low run, and this is caught at the cycle the run should have ended. A wrong enable or pending flag shows up on the first completion strobe: an acknowledge appears where none belongs, or a status flag is missing. The reference model compares every output on every cycle, so a mismatch is reported in the cycle it first reaches a port.

// File: rtl/dph_pkg.sv
package dph_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ACK_LOW   = 3'd1,
    ST_ACK_SPD   = 3'd2,
    ST_SYNC_WAIT = 3'd3,
    ST_RESP_LOW  = 3'd4,
    ST_RESP_SPD  = 3'd5
  } hs_state_e;
endpackage

// File: rtl/dph_sync2.sv
module dph_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dph_low_timer.sv
module dph_low_timer #(
  parameter int SYNC_MIN = 128,
  localparam int CW = $clog2(SYNC_MIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic hold,
  output logic sync_hit
);
  localparam logic [CW-1:0] SAT = CW'(SYNC_MIN);
  localparam logic [CW-1:0] LAST = CW'(SYNC_MIN - 1);

  logic [CW-1:0] low_cnt;

  // Counter saturates at SAT so a long low gives one hit only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (hold || pin_s)    low_cnt <= '0;
    else if (low_cnt != SAT)   low_cnt <= low_cnt + 1'b1;
  end

  assign sync_hit = !hold && !pin_s && (low_cnt == LAST);
endmodule

// File: rtl/dph_pulse_fsm.sv
module dph_pulse_fsm
  import dph_pkg::*;
#(
  parameter int ACK_LEN  = 16,
  parameter int RESP_LEN = 128,
  localparam int TW = $clog2((ACK_LEN > RESP_LEN ? ACK_LEN : RESP_LEN) + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_hit,
  input  logic      pin_s,
  input  logic      ack_go,
  output logic      drive_low,
  output logic      drive_high,
  output logic      resp_active,
  output hs_state_e state_o
);
  hs_state_e       st, st_nx;
  logic [TW-1:0]   tmr, tmr_nx;
  logic            hi1, hi1_nx;

  always_comb begin
    st_nx  = st;
    tmr_nx = tmr;
    hi1_nx = hi1;
    unique case (st)
      ST_IDLE: begin
        if (sync_hit) begin
          st_nx = ST_SYNC_WAIT; hi1_nx = 1'b0;
        end else if (ack_go) begin
          st_nx = ST_ACK_LOW; tmr_nx = TW'(ACK_LEN - 1);
        end
      end
      ST_ACK_LOW: begin
        if (sync_hit) begin
          st_nx = ST_SYNC_WAIT; hi1_nx = 1'b0;
        end else if (tmr == '0) st_nx = ST_ACK_SPD;
        else tmr_nx = tmr - 1'b1;
      end
      ST_ACK_SPD: begin
        if (sync_hit) begin
          st_nx = ST_SYNC_WAIT; hi1_nx = 1'b0;
        end else st_nx = ST_IDLE;
      end
      ST_SYNC_WAIT: begin
        hi1_nx = pin_s;
        if (pin_s && hi1) begin
          st_nx = ST_RESP_LOW; tmr_nx = TW'(RESP_LEN - 1);
        end
      end
      ST_RESP_LOW: begin
        if (tmr == '0) st_nx = ST_RESP_SPD;
        else tmr_nx = tmr - 1'b1;
      end
      ST_RESP_SPD: st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      tmr <= '0;
      hi1 <= 1'b0;
    end else begin
      st  <= st_nx;
      tmr <= tmr_nx;
      hi1 <= hi1_nx;
    end
  end

  assign drive_low   = (st == ST_ACK_LOW) || (st == ST_RESP_LOW);
  assign drive_high  = (st == ST_ACK_SPD) || (st == ST_RESP_SPD);
  assign resp_active = (st == ST_RESP_LOW) || (st == ST_RESP_SPD);
  assign state_o     = st;
endmodule

// File: rtl/dbg_pin_handshake.sv
module dbg_pin_handshake
  import dph_pkg::*;
#(
  parameter int SYNC_MIN = 128,
  parameter int ACK_LEN  = 16,
  parameter int RESP_LEN = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic cmd_start,
  input  logic cmd_done,
  input  logic ack_on_cmd,
  input  logic ack_off_cmd,
  output logic pin_drive_low,
  output logic pin_drive_high,
  output logic cmd_abort,
  output logic status_valid
);
  logic      pin_s, sync_hit, resp_active, ack_go;
  logic      pending_q, ack_en_q, status_q;
  hs_state_e fsm_state;

  dph_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(pin_s)
  );

  dph_low_timer #(.SYNC_MIN(SYNC_MIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .hold(resp_active),
    .sync_hit(sync_hit)
  );

  dph_pulse_fsm #(.ACK_LEN(ACK_LEN), .RESP_LEN(RESP_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sync_hit(sync_hit), .pin_s(pin_s),
    .ack_go(ack_go), .drive_low(pin_drive_low), .drive_high(pin_drive_high),
    .resp_active(resp_active), .state_o(fsm_state)
  );

  assign ack_go = cmd_done && pending_q && ack_en_q && !sync_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ack_en_q  <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      // sync wins over everything, a new start over a stale done
      if (sync_hit)       pending_q <= 1'b0;
      else if (cmd_start) pending_q <= 1'b1;
      else if (cmd_done)  pending_q <= 1'b0;

      if (ack_off_cmd)     ack_en_q <= 1'b0;
      else if (ack_on_cmd) ack_en_q <= 1'b1;

      if (cmd_start) status_q <= 1'b0;
      else if (cmd_done && pending_q && !sync_hit) status_q <= 1'b1;
    end
  end

  assign cmd_abort    = sync_hit && pending_q;
  assign status_valid = status_q;
endmodule

// File: rtl/dbg_pin_handshake_chk.sv
module dbg_pin_handshake_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_done,
  input logic pin_drive_low,
  input logic pin_drive_high,
  input logic cmd_abort,
  input logic status_valid,
  input logic pending_q,
  input logic ack_en_q,
  input logic sync_hit,
  input logic cmd_start
);
  a_r8_drive_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_drive_low && pin_drive_high));

  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);

  a_r6_abort_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !pending_q);

  a_r2_speedup_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_drive_high) |-> $past(pin_drive_low));

  a_r4_status_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && pending_q && !sync_hit && !cmd_start) |=> status_valid);

  a_r4_no_ack_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !ack_en_q && !pin_drive_low && !pin_drive_high) |=> !pin_drive_low || $past(sync_hit) || $past(pin_drive_low));
endmodule

bind dbg_pin_handshake dbg_pin_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done),
  .pin_drive_low(pin_drive_low), .pin_drive_high(pin_drive_high),
  .cmd_abort(cmd_abort), .status_valid(status_valid),
  .pending_q(pending_q), .ack_en_q(ack_en_q), .sync_hit(sync_hit),
  .cmd_start(cmd_start)
);

// File: tb/dbg_pin_handshake_test.sv
module dbg_pin_handshake_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic cmd_start = 1'b0, cmd_done = 1'b0, ack_on_cmd = 1'b0, ack_off_cmd = 1'b0;
  logic pin_drive_low, pin_drive_high, cmd_abort, status_valid;
  logic pin_in;

  always #2 clk = ~clk;

  assign pin_in = !(host_low || pin_drive_low);

  dbg_pin_handshake uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmd_start(cmd_start),
    .cmd_done(cmd_done), .ack_on_cmd(ack_on_cmd), .ack_off_cmd(ack_off_cmd),
    .pin_drive_low(pin_drive_low), .pin_drive_high(pin_drive_high),
    .cmd_abort(cmd_abort), .status_valid(status_valid)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  // reference model: plain integers
  int m_s1 = 1, m_s2 = 1, m_cnt = 0, m_st = 0, m_tmr = 0, m_hi1 = 0;
  int m_pend = 0, m_ackon = 0, m_stat = 0;
  int run_low = 0, last_low = 0, aborts = 0, recog = 0, resp_runs = 0;

  function automatic int m_dl(); return (m_st == 1 || m_st == 4) ? 1 : 0; endfunction
  function automatic int m_dh(); return (m_st == 2 || m_st == 5) ? 1 : 0; endfunction
  function automatic int m_hit();
    return (m_st < 4 && m_s2 == 0 && m_cnt == 127) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      int pin, hit, go, n_cnt, n_st, n_tmr, n_hi1;
      pin = (host_low || m_dl() == 1) ? 0 : 1;
      hit = m_hit();
      go = (cmd_done && m_pend == 1 && m_ackon == 1 && hit == 0) ? 1 : 0;
      n_cnt = (m_st >= 4 || m_s2 == 1) ? 0 : (m_cnt == 128 ? 128 : m_cnt + 1);
      n_st = m_st; n_tmr = m_tmr; n_hi1 = m_hi1;
      if (m_st <= 2 && hit == 1) begin n_st = 3; n_hi1 = 0; end
      else if (m_st == 0 && go == 1) begin n_st = 1; n_tmr = 15; end
      else if (m_st == 1) begin if (m_tmr == 0) n_st = 2; else n_tmr = m_tmr - 1; end
      else if (m_st == 2) n_st = 0;
      else if (m_st == 3) begin
        n_hi1 = m_s2;
        if (m_s2 == 1 && m_hi1 == 1) begin n_st = 4; n_tmr = 127; end
      end
      else if (m_st == 4) begin if (m_tmr == 0) n_st = 5; else n_tmr = m_tmr - 1; end
      else if (m_st == 5) n_st = 0;
      if (hit == 1) begin recog++; if (m_pend == 1) aborts++; end
      if (cmd_start) m_stat = 0;
      else if (cmd_done && m_pend == 1 && hit == 0) m_stat = 1;
      if (hit == 1) m_pend = 0;
      else if (cmd_start) m_pend = 1;
      else if (cmd_done) m_pend = 0;
      if (ack_off_cmd) m_ackon = 0; else if (ack_on_cmd) m_ackon = 1;
      m_s2 = m_s1; m_s1 = pin;
      m_cnt = n_cnt; m_st = n_st; m_tmr = n_tmr; m_hi1 = n_hi1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(pin_drive_low == m_dl(), "R2/R5 drive_low", pin_drive_low, m_dl());
      chk(pin_drive_high == m_dh(), "R2/R5 drive_high", pin_drive_high, m_dh());
      chk(cmd_abort == (m_hit() == 1 && m_pend == 1), "R6 abort", cmd_abort, m_hit() & m_pend);
      chk(status_valid == m_stat, "R4 status", status_valid, m_stat);
      chk(!(pin_drive_low && pin_drive_high), "R8 exclusive", pin_drive_high, 0);
      if (pin_drive_low) run_low++;
      else if (run_low != 0) begin
        last_low = run_low; run_low = 0;
        if (last_low == 128) resp_runs++;
      end
      if (cycles > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_start(); cmd_start = 1; tick(1); cmd_start = 0; endtask
  task automatic pulse_done();  cmd_done = 1;  tick(1); cmd_done = 0; endtask

  initial begin
    tick(3);
    chk(pin_drive_low == 0 && pin_drive_high == 0 && cmd_abort == 0 && status_valid == 0,
        "R3 reset state", {pin_drive_low, pin_drive_high, cmd_abort, status_valid}, 0);
    rst_n = 1;
    tick(5);
    // R3/R4: disabled after reset, completion still flags status
    pulse_start(); tick(3); pulse_done(); tick(25);
    chk(last_low == 0, "R3 no ack after reset", last_low, 0);
    chk(status_valid == 1, "R4 status set", status_valid, 1);
    pulse_start();
    chk(status_valid == 0, "R4 status cleared by start", status_valid, 0);
    // R2: enabled acknowledge
    ack_on_cmd = 1; tick(1); ack_on_cmd = 0;
    tick(2); pulse_done(); tick(25);
    chk(last_low == 16, "R2 ack length", last_low, 16);
    // R3: both strobes, disable wins
    ack_on_cmd = 1; ack_off_cmd = 1; tick(1); ack_on_cmd = 0; ack_off_cmd = 0;
    last_low = 0; pulse_start(); tick(2); pulse_done(); tick(25);
    chk(last_low == 0, "R3 disable wins", last_low, 0);
    // R1: 127-sample low is not a sync
    host_low = 1; tick(127); host_low = 0; tick(140);
    chk(recog == 0 && last_low == 0, "R1 short low ignored", recog, 0);
    // R1/R5/R6/R9: long low with pending command
    pulse_start(); host_low = 1; tick(400); host_low = 0; tick(150);
    chk(recog == 1, "R9 single recognition", recog, 1);
    chk(aborts == 1, "R6 abort count", aborts, 1);
    chk(resp_runs == 1, "R5 response length 128", resp_runs, 1);
    tick(200);
    chk(recog == 1, "R10 own response not a sync", recog, 1);
    pulse_done(); tick(25);
    chk(status_valid == 0 && last_low == 128, "R6 aborted done ignored", status_valid, 0);
    // R7: sync overlapping an acknowledge
    ack_on_cmd = 1; tick(1); ack_on_cmd = 0;
    pulse_start(); host_low = 1; tick(120);
    pulse_done(); tick(30); host_low = 0; tick(150);
    chk(recog == 2, "R7 sync recognised during ack", recog, 2);
    chk(resp_runs == 2, "R7 response follows", resp_runs, 2);
    tick(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule